// File: doc/BRIEF.md
# Linked-Descriptor Byte DMA Channel

This block is one memory-to-memory copy engine. Software loads four working registers (byte count, source pointer, destination pointer, pointer to the following descriptor) and a control word. When the control word's enable bit goes from 0 to 1, the channel copies the block one byte at a time. Each byte is one read on the byte-wide memory port, followed by one write. Each pointer moves up, moves down or stays put, as its own two-bit code selects.

When a block is finished, the channel can fetch a new descriptor of four 32-bit words through a separate word read port. It then carries on with that block. This repeats until it meets a zero next pointer, or until the control word asks for a single block only. A one-cycle completion pulse feeds an interrupt cause register. A control bit chooses whether that pulse fires after every block or only once, when the whole list is finished.

Top module: `dma_chain_channel`

## Requirements
- R1: After reset all five registers read as 0, no memory or fetch request is pending and the completion pulse is low. The register index is 0 count, 1 source, 2 destination, 3 next pointer, 4 control.
- R2: A control write that moves bit 12 from 0 to 1 starts a copy. While the copy runs, control bits 12 and 14 both read 1. A software write never changes bit 14.
- R3: Control bit 13 always reads 0. Writing it as 1 makes the channel fetch the next descriptor. If the same write also raises bit 12, the copy of the new block follows the fetch.
- R4: Each byte is moved by one read at the source address and then one write of that byte at the destination address. A request holds its address and direction until it is acknowledged, and the next request starts only after that.
- R5: Control bits [3:2] select how the source address steps and bits [5:4] select how the destination address steps. Code 0 adds 1, code 1 subtracts 1, code 2 holds, and code 3 adds 1.
- R6: The block length is count bits [15:0] only. After a block, bits [15:0] read 0 and bits [31:16] are unchanged. The source and destination registers hold the address that follows the last byte moved.
- R7: A descriptor is read as four word requests at next, next+4, next+8 and next+12. These load count, source, destination and next pointer, in that order. Each request is a valid/ready handshake and its address is held while ready is low.
- R8: The list ends when the next pointer is 0, or after the current block when control bit 9 is 1. At the end, control bits 12 and 14 read 0.
- R9: With control bit 10 at 0, the completion pulse goes high for exactly one cycle after every block.
- R10: With control bit 10 at 1, exactly one completion pulse appears for the whole list, when it ends.
- R11: A block whose low 16 count bits are 0 makes no memory access and still counts as a completed block.
- R12: While the channel is busy, all register writes are ignored.
- R13: A fetch request made when bit 9 is 1 or the next pointer is 0 issues no word read and ends the list. It pulses only if bit 10 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register index for the write |
| reg_wdata | input | ADDR_W | Write data |
| reg_raddr | input | 3 | Register index for the read |
| reg_rdata | output | ADDR_W | Read data (combinational) |
| mem_req | output | 1 | Byte access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_ack | input | 1 | Access acknowledge |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| fetch_valid | output | 1 | Descriptor word request |
| fetch_addr | output | ADDR_W | Descriptor word address |
| fetch_ready | input | 1 | Word accepted, data valid this cycle |
| fetch_data | input | ADDR_W | Descriptor word |
| done_pulse | output | 1 | Completion pulse for the interrupt cause |

## Verification
The bound checker watches the port protocols on every cycle. It checks that the byte and word masters are never active together, that a pending request keeps its address, and that every acknowledged read is followed at once by a write. It also checks that descriptor words step by four inside one fetch, that the pulse lasts only one cycle and is never raised while a request is open, that bit 13 reads 0, and that the busy bits are set whenever a byte request is out. The bench's reference model covers what only whole scenarios can show: the stepping codes, the count preserving its upper half, where the list stops, how many pulses each interrupt mode gives, and that register writes are ignored while the channel is busy.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COPY_CHK,
        ST_RD,
        ST_WR,
        ST_BLK_DONE,
        ST_NEXT_CHK,
        ST_FETCH
    } dma_state_e;

    typedef enum logic [1:0] {
        STEP_UP   = 2'd0,
        STEP_DOWN = 2'd1,
        STEP_HOLD = 2'd2,
        STEP_ALT  = 2'd3
    } step_mode_e;

    // control word bit positions
    localparam int unsigned BIT_SRC_LO  = 2;
    localparam int unsigned BIT_DST_LO  = 4;
    localparam int unsigned BIT_SINGLE  = 9;
    localparam int unsigned BIT_IRQ_END = 10;
    localparam int unsigned BIT_ENABLE  = 12;
    localparam int unsigned BIT_FETCH   = 13;
    localparam int unsigned BIT_ACTIVE  = 14;

    // register indices
    localparam logic [2:0] IDX_COUNT = 3'd0;
    localparam logic [2:0] IDX_SRC   = 3'd1;
    localparam logic [2:0] IDX_DST   = 3'd2;
    localparam logic [2:0] IDX_NEXT  = 3'd3;
    localparam logic [2:0] IDX_CTRL  = 3'd4;

endpackage

// File: rtl/dma_addr_stepper.sv
module dma_addr_stepper
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        mode_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] UNIT = ADDR_W'(1);

    always_comb begin
        case (mode_i)
            STEP_DOWN: addr_o = addr_i - UNIT;
            STEP_HOLD: addr_o = addr_i;
            default:   addr_o = addr_i + UNIT;   // STEP_UP and STEP_ALT
        endcase
    end
endmodule

// File: rtl/dma_desc_loader.sv
module dma_desc_loader #(
    parameter int ADDR_W = 32,
    parameter int WORDS  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [ADDR_W-1:0]        base_i,
    input  logic                     ready_i,
    output logic                     valid_o,
    output logic [ADDR_W-1:0]        addr_o,
    output logic                     take_o,
    output logic [$clog2(WORDS)-1:0] idx_o,
    output logic                     last_o
);
    localparam int IW    = $clog2(WORDS);
    localparam int SHIFT = $clog2(ADDR_W / 8);
    localparam logic [IW-1:0] LAST_IDX = IW'(WORDS - 1);

    typedef struct packed {
        logic              active;
        logic [IW-1:0]     idx;
        logic [ADDR_W-1:0] base;
    } ld_t;

    ld_t ld_d, ld_q;

    always_comb begin
        ld_d   = ld_q;
        take_o = ld_q.active && ready_i;
        last_o = take_o && (ld_q.idx == LAST_IDX);
        if (start_i) begin
            ld_d.active = 1'b1;
            ld_d.idx    = '0;
            ld_d.base   = base_i;
        end else if (take_o) begin
            if (last_o) ld_d.active = 1'b0;
            else        ld_d.idx    = ld_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ld_q <= '0;
        else        ld_q <= ld_d;
    end

    assign valid_o = ld_q.active;
    assign idx_o   = ld_q.idx;
    assign addr_o  = ld_q.base + ({{(ADDR_W-IW){1'b0}}, ld_q.idx} << SHIFT);
endmodule

// File: rtl/dma_chain_channel.sv
module dma_chain_channel
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_waddr,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic [2:0]        reg_raddr,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    output logic              fetch_valid,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_ready,
    input  logic [ADDR_W-1:0] fetch_data,
    output logic              done_pulse
);
    localparam int DESC_WORDS = 4;
    localparam int IW         = $clog2(DESC_WORDS);
    localparam int N_PTR      = 2;          // source and destination steppers

    typedef struct packed {
        dma_state_e        st;
        logic [ADDR_W-1:0] cnt;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] nxt;
        logic [ADDR_W-1:0] ctl;
        logic [7:0]        byte_hold;
        logic              run;
    } chan_t;

    chan_t r_d, r_q;

    logic [CNT_W-1:0]  blk_left;
    logic              chain_end;
    logic              en_rise;
    logic              ld_start, ld_take, ld_last;
    logic [IW-1:0]     ld_idx;
    logic [ADDR_W-1:0] step_cur [N_PTR];
    logic [1:0]        step_mode[N_PTR];
    logic [ADDR_W-1:0] step_nxt [N_PTR];

    assign blk_left  = r_q.cnt[CNT_W-1:0];
    assign chain_end = r_q.ctl[BIT_SINGLE] || (r_q.nxt == '0);
    assign en_rise   = reg_wdata[BIT_ENABLE] && !r_q.ctl[BIT_ENABLE];

    always_comb begin
        step_cur[0]  = r_q.src;
        step_cur[1]  = r_q.dst;
        step_mode[0] = r_q.ctl[BIT_SRC_LO +: 2];
        step_mode[1] = r_q.ctl[BIT_DST_LO +: 2];
    end

    for (genvar g = 0; g < N_PTR; g++) begin : g_step
        dma_addr_stepper #(.ADDR_W(ADDR_W)) u_step (
            .addr_i (step_cur[g]),
            .mode_i (step_mode[g]),
            .addr_o (step_nxt[g])
        );
    end

    dma_desc_loader #(.ADDR_W(ADDR_W), .WORDS(DESC_WORDS)) u_loader (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (ld_start),
        .base_i  (r_q.nxt),
        .ready_i (fetch_ready),
        .valid_o (fetch_valid),
        .addr_o  (fetch_addr),
        .take_o  (ld_take),
        .idx_o   (ld_idx),
        .last_o  (ld_last)
    );

    always_comb begin
        r_d      = r_q;
        ld_start = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (reg_wr) begin
                    case (reg_waddr)
                        IDX_COUNT: r_d.cnt = reg_wdata;
                        IDX_SRC:   r_d.src = reg_wdata;
                        IDX_DST:   r_d.dst = reg_wdata;
                        IDX_NEXT:  r_d.nxt = reg_wdata;
                        IDX_CTRL: begin
                            r_d.ctl             = reg_wdata;
                            r_d.ctl[BIT_FETCH]  = 1'b0;
                            r_d.ctl[BIT_ACTIVE] = r_q.ctl[BIT_ACTIVE];
                            if (reg_wdata[BIT_FETCH]) begin
                                r_d.st  = ST_NEXT_CHK;
                                r_d.run = en_rise;
                            end else if (en_rise) begin
                                r_d.st              = ST_COPY_CHK;
                                r_d.run             = 1'b1;
                                r_d.ctl[BIT_ACTIVE] = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_COPY_CHK: begin
                r_d.st = (blk_left == '0) ? ST_BLK_DONE : ST_RD;
            end
            ST_RD: begin
                if (mem_ack) begin
                    r_d.byte_hold = mem_rdata;
                    r_d.src       = step_nxt[0];
                    r_d.st        = ST_WR;
                end
            end
            ST_WR: begin
                if (mem_ack) begin
                    r_d.dst              = step_nxt[1];
                    r_d.cnt[CNT_W-1:0]   = blk_left - 1'b1;
                    r_d.st               = (blk_left == CNT_W'(1)) ? ST_BLK_DONE : ST_RD;
                end
            end
            ST_BLK_DONE: begin
                r_d.st  = ST_NEXT_CHK;
                r_d.run = 1'b1;
            end
            ST_NEXT_CHK: begin
                if (chain_end) begin
                    r_d.ctl[BIT_ENABLE] = 1'b0;
                    r_d.ctl[BIT_ACTIVE] = 1'b0;
                    r_d.run             = 1'b0;
                    r_d.st              = ST_IDLE;
                end else begin
                    ld_start = 1'b1;
                    r_d.st   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (ld_take) begin
                    case (ld_idx)
                        2'd0:    r_d.cnt = fetch_data;
                        2'd1:    r_d.src = fetch_data;
                        2'd2:    r_d.dst = fetch_data;
                        default: r_d.nxt = fetch_data;
                    endcase
                end
                if (ld_last) begin
                    if (r_q.run) begin
                        r_d.st              = ST_COPY_CHK;
                        r_d.ctl[BIT_ACTIVE] = 1'b1;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mem_req   = (r_q.st == ST_RD) || (r_q.st == ST_WR);
    assign mem_we    = (r_q.st == ST_WR);
    assign mem_addr  = (r_q.st == ST_WR) ? r_q.dst : r_q.src;
    assign mem_wdata = r_q.byte_hold;

    assign done_pulse = ((r_q.st == ST_BLK_DONE) && !r_q.ctl[BIT_IRQ_END]) ||
                        ((r_q.st == ST_NEXT_CHK) && chain_end && r_q.ctl[BIT_IRQ_END]);

    always_comb begin
        case (reg_raddr)
            IDX_COUNT: reg_rdata = r_q.cnt;
            IDX_SRC:   reg_rdata = r_q.src;
            IDX_DST:   reg_rdata = r_q.dst;
            IDX_NEXT:  reg_rdata = r_q.nxt;
            IDX_CTRL:  reg_rdata = r_q.ctl;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_chain_channel_chk.sv
module dma_chain_channel_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        reg_raddr,
    input logic [ADDR_W-1:0] reg_rdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              fetch_ready,
    input logic              done_pulse
);
    logic [1:0] words_taken;

    always_ff @(posedge clk) begin
        if (!rst_n)                          words_taken <= '0;
        else if (fetch_valid && fetch_ready) words_taken <= words_taken + 1'b1;
    end

    p_one_master_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && fetch_valid));

    p_mem_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_read_then_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we));

    p_fetch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !fetch_ready) |=> (fetch_valid && $stable(fetch_addr)));

    p_fetch_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_ready && words_taken != 2'd3)
        |=> (fetch_valid && fetch_addr == $past(fetch_addr) + ADDR_W'(4)));

    p_fetch_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_ready && words_taken == 2'd3) |=> !fetch_valid);

    p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    p_pulse_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (!mem_req && !fetch_valid));

    p_fetch_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_raddr == 3'd4) |-> !reg_rdata[13]);

    p_busy_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && reg_raddr == 3'd4) |-> (reg_rdata[12] && reg_rdata[14]));
endmodule

bind dma_chain_channel dma_chain_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_raddr   (reg_raddr),
    .reg_rdata   (reg_rdata),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .fetch_ready (fetch_ready),
    .done_pulse  (done_pulse)
);

// File: tb/dma_chain_channel_test.sv
`timescale 1ns/1ps
module dma_chain_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        fetch_valid;
    logic [31:0] fetch_addr;
    logic        fetch_ready = 1'b0;
    logic [31:0] fetch_data = '0;
    logic        done_pulse;

    always #2 clk = ~clk;   // 250 MHz

    dma_chain_channel uut (.*);

    int vectors = 0, miscomp = 0, pulses = 0, dseed = 0;
    bit [7:0]  bmem  [int unsigned];   // memory seen by the design
    bit [7:0]  shmem [int unsigned];   // model memory
    bit [31:0] dmem  [int unsigned];   // descriptor words
    bit        q_we  [$];
    bit [31:0] q_addr[$];
    bit [7:0]  q_data[$];
    bit [31:0] q_fet [$];
    bit [31:0] e_cnt, e_src, e_dst, e_nxt;
    int        e_pulses;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscomp++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit [7:0] pat(input bit [31:0] a);
        return a[7:0] ^ 8'h5A ^ a[15:8];
    endfunction

    function automatic bit [31:0] stp(input bit [31:0] a, input bit [1:0] m);
        case (m)
            2'd1:    return a - 1;
            2'd2:    return a;
            default: return a + 1;
        endcase
    endfunction

    // behavioural reference: walks the list and queues expected traffic
    task automatic model(input bit [31:0] c, s, d, n, ctl);
        e_pulses = 0;
        for (int blk = 0; blk < 16; blk++) begin
            for (int i = 0; i < int'(c[15:0]); i++) begin
                bit [7:0] b;
                b = shmem.exists(s) ? shmem[s] : pat(s);
                q_we.push_back(1'b0); q_addr.push_back(s); q_data.push_back(b);
                q_we.push_back(1'b1); q_addr.push_back(d); q_data.push_back(b);
                shmem[d] = b;
                s = stp(s, ctl[3:2]);
                d = stp(d, ctl[5:4]);
            end
            c[15:0] = 16'h0;
            if (!ctl[10]) e_pulses++;
            if (ctl[9] || n == 0) begin
                if (ctl[10]) e_pulses++;
                break;
            end
            for (int k = 0; k < 4; k++) q_fet.push_back(n + 4*k);
            c = dmem[n]; s = dmem[n+4]; d = dmem[n+8]; n = dmem[n+12];
        end
        e_cnt = c; e_src = s; e_dst = d; e_nxt = n;
    endtask

    // byte memory responder, compares every access against the model
    int  mdly;
    bit  mseen;
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0; mseen = 1'b0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (!mseen) begin
                mseen = 1'b1; mdly = dseed % 3; dseed++;
                if (q_we.size() == 0) begin
                    vectors++; miscomp++;
                    $display("FAIL R4 unexpected access actual=%h expected=none", mem_addr);
                end else begin
                    bit ew; bit [31:0] ea; bit [7:0] ed;
                    ew = q_we.pop_front(); ea = q_addr.pop_front(); ed = q_data.pop_front();
                    chk("R4 access direction", {31'b0, mem_we}, {31'b0, ew});
                    chk("R5 access address", mem_addr, ea);
                    if (mem_we) chk("R4 written byte", {24'b0, mem_wdata}, {24'b0, ed});
                end
            end
            if (mdly == 0) begin
                mem_ack = 1'b1; mseen = 1'b0;
                if (mem_we) bmem[mem_addr] = mem_wdata;
                else mem_rdata = bmem.exists(mem_addr) ? bmem[mem_addr] : pat(mem_addr);
            end else mdly--;
        end
    end

    // descriptor word responder
    int  fdly;
    bit  fseen;
    always @(negedge clk) begin
        if (!rst_n) begin
            fetch_ready = 1'b0; fseen = 1'b0;
        end else if (fetch_ready) begin
            fetch_ready = 1'b0;
        end else if (fetch_valid) begin
            if (!fseen) begin
                fseen = 1'b1; fdly = dseed % 2; dseed++;
                if (q_fet.size() == 0) begin
                    vectors++; miscomp++;
                    $display("FAIL R7 unexpected fetch actual=%h expected=none", fetch_addr);
                end else chk("R7 fetch address", fetch_addr, q_fet.pop_front());
            end
            if (fdly == 0) begin
                fetch_ready = 1'b1; fseen = 1'b0;
                fetch_data = dmem.exists(fetch_addr) ? dmem[fetch_addr] : 32'h0;
            end else fdly--;
        end
    end

    always @(negedge clk) if (rst_n && done_pulse) pulses++;

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_raddr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        bit done = 0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 5000 && !done; i++) begin
            rd(3'd4, v);
            if (!v[12] && !v[14]) done = 1;
            else @(negedge clk);
        end
        if (!done) chk("R8 channel never ended", v, 32'h0);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_end(input string tag);
        logic [31:0] v;
        rd(3'd0, v); chk({tag, " R6 count"}, v, e_cnt);
        rd(3'd1, v); chk({tag, " R6 source"}, v, e_src);
        rd(3'd2, v); chk({tag, " R6 destination"}, v, e_dst);
        rd(3'd3, v); chk({tag, " R7 next"}, v, e_nxt);
        rd(3'd4, v); chk({tag, " R8 busy bits"}, {30'b0, v[14], v[12]}, 32'h0);
        chk({tag, " R9 pulse count"}, pulses, e_pulses);
        chk({tag, " R4 left traffic"}, q_we.size() + q_fet.size(), 0);
    endtask

    task automatic run_block(input string tag, input bit [31:0] c, s, d, n, ctl, input bit poke);
        logic [31:0] v;
        wr(3'd0, c); wr(3'd1, s); wr(3'd2, d); wr(3'd3, n);
        model(c, s, d, n, ctl);
        pulses = 0;
        wr(3'd4, ctl | 32'h1000);
        if (poke) begin
            repeat (2) @(negedge clk);
            rd(3'd4, v); chk("R2 busy bits while running", {30'b0, v[14], v[12]}, 32'h3);
            wr(3'd1, 32'hDEAD_0000);   // R12: ignored while busy
            wr(3'd4, 32'h0);           // R12: ignored while busy
        end
        wait_idle();
        check_end(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++; miscomp++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 5; i++) begin
            rd(3'(i), v); chk("R1 register after reset", v, 32'h0);
        end
        chk("R1 idle outputs", {29'b0, mem_req, fetch_valid, done_pulse}, 32'h0);

        // R2 activity bit cannot be written
        wr(3'd4, 32'h0000_4024);
        rd(3'd4, v); chk("R2 bit14 write ignored", v, 32'h0000_0024);
        wr(3'd4, 32'h0);

        // R13 / R3 fetch request in single-block mode: no reads, one pulse
        wr(3'd3, 32'h0000_1000);
        pulses = 0;
        wr(3'd4, 32'h0000_2600);
        repeat (10) @(negedge clk);
        rd(3'd4, v); chk("R3 bit13 reads zero", v, 32'h0000_0600);
        chk("R13 pulse on refused fetch", pulses, 1);
        chk("R13 no fetch traffic", q_fet.size(), 0);
        wr(3'd4, 32'h0);

        // R6 R12 single block, upper count bits kept
        run_block("S1", 32'hABCD_0006, 32'h100, 32'h200, 32'h1000, 32'h200, 1);
        // R5 source down, destination hold
        run_block("S2", 32'h4, 32'h31F, 32'h400, 32'h0, 32'h224, 0);
        // R5 code 3 source up, destination down
        run_block("S3", 32'h3, 32'h500, 32'h6FF, 32'h0, 32'h21C, 0);

        // descriptor list: 0x1000 -> 0x1010 -> end; R11 second block zero length
        dmem[32'h1000] = 32'h0000_0003; dmem[32'h1004] = 32'h700;
        dmem[32'h1008] = 32'h800;       dmem[32'h100C] = 32'h1010;
        dmem[32'h1010] = 32'hFFFF_0000; dmem[32'h1014] = 32'h900;
        dmem[32'h1018] = 32'hA00;       dmem[32'h101C] = 32'h0;

        // R7 R8 R9 pulse per block
        run_block("S4", 32'h2, 32'h600, 32'h680, 32'h1000, 32'h0, 0);
        chk("R9 three blocks three pulses", pulses, 3);
        // R10 one pulse for the list
        run_block("S5", 32'h2, 32'h640, 32'h6C0, 32'h1000, 32'h400, 0);
        chk("R10 single pulse at list end", pulses, 1);

        // R3 software fetch alone loads the descriptor, moves nothing
        wr(3'd3, 32'h1000);
        for (int k = 0; k < 4; k++) q_fet.push_back(32'h1000 + 4*k);
        pulses = 0;
        wr(3'd4, 32'h2000);
        repeat (40) @(negedge clk);
        e_cnt = 32'h3; e_src = 32'h700; e_dst = 32'h800; e_nxt = 32'h1010; e_pulses = 0;
        check_end("S6 R3");

        // R3 fetch plus enable: fetch 0x1010, then R11 empty block, end
        for (int k = 0; k < 4; k++) q_fet.push_back(32'h1010 + 4*k);
        model(32'hFFFF_0000, 32'h900, 32'hA00, 32'h0, 32'h0);
        pulses = 0;
        wr(3'd4, 32'h3000);
        wait_idle();
        check_end("S7 R11");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end
endmodule